// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns parallel words into asynchronous NRZ character frames on a single serial output line. A word is offered on a valid/ready handshake. Once accepted, the block sends a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop bit. After the stop bit the line rests high, so the next start bit always begins with a falling edge. A flag offered with the word asks for an idle character instead: all ones, lasting as long as a normal frame.

Static configuration picks the word length (8 or 9 bits), the parity treatment and a 13-bit baud divisor that gives the bit time in clock cycles. The block holds its own bit-time counter. In single-wire mode the output driver is enabled only while a frame is in flight, which frees the shared pin for receiving between frames.

Top module: `sci_frame_tx`

## Requirements
- R1: After reset, `txd_o` is 1, `busy` is 0 and `in_ready` is 1. `txd_oe` is 1 when `cfg_single` is 0 and 0 when `cfg_single` is 1.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1. With `in_idle` at 0, the first bit time after that edge is a start bit with `txd_o` at 0.
- R3: The data bits follow the start bit, least significant first. `cfg_nine` = 1 sends `in_data[8:0]`. `cfg_nine` = 0 sends `in_data[7:0]`, and `in_data[8]` is neither sent nor counted in parity.
- R4: `cfg_par` selects the bit placed right after the data MSB. 0 = no parity bit, 1 = mark (always 1), 2 = space (always 0), 3 = even (data ones plus parity is even), 4 = odd (that total is odd). Codes 5 to 7 behave as 0.
- R5: One high stop bit ends every frame, and `txd_o` stays 1 whenever `busy` is 0.
- R6: Every bit lasts D clock cycles, where D is `cfg_div` captured when the word is accepted, with 0 treated as 1. Changing `cfg_div` during a frame does not affect that frame.
- R7: With `in_idle` at 1, the accepted request sends all ones for as many bit times as a frame of the current word length and parity setting (1 + word length + parity + 1).
- R8: `in_ready` is 0 and `busy` is 1 from the cycle after acceptance to the end of the stop bit. Words offered in that window are not taken. A word held valid is accepted on the first edge after the frame, so its start bit follows one clock after the stop bit.
- R9: With `cfg_single` at 1, `txd_oe` is 1 only while `busy` is 1. With `cfg_single` at 0, `txd_oe` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_nine | input | 1 | 1 selects 9-bit words, 0 selects 8-bit words |
| cfg_par | input | 3 | Parity mode code (see R4) |
| cfg_div | input | 13 | Clock cycles per bit (0 acts as 1) |
| cfg_single | input | 1 | Single-wire mode: drive the pin only during frames |
| in_valid | input | 1 | Word or idle request offered |
| in_idle | input | 1 | Offered request is an idle character |
| in_data | input | 9 | Word to send |
| in_ready | output | 1 | Block can accept a request |
| busy | output | 1 | Frame in flight |
| txd_o | output | 1 | Serial line value |
| txd_oe | output | 1 | Output enable for the serial pin |

## Verification
Bit i of a frame accepted at edge k sits on `txd_o` from edge k + i·D to edge k + (i+1)·D. `busy` and `in_ready` change at edge k and again at edge k + len·D. The bench drives its inputs and samples at falling edges. After each acceptance it walks the expected bit list one falling edge at a time: D samples per bit, then one sample after the last bit, where the line must be high and ready. So each result is compared in exactly the cycle it is due. A sweep over word length, every parity code, several divisors, both pin modes and a set of data patterns fixes every frame's layout and duration. During each frame the bench changes `cfg_div` and offers another word, to show that neither has any effect.

// File: rtl/sci_tx_pkg.sv
// Package: shared parity-mode encoding for the serial frame transmitter.
// Assumes codes outside the listed set mean "no parity bit".
package sci_tx_pkg;
    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_MARK  = 3'd1,
        PAR_SPACE = 3'd2,
        PAR_EVEN  = 3'd3,
        PAR_ODD   = 3'd4
    } par_mode_e;
endpackage

// File: rtl/sci_tx_baud.sv
// Module: bit-time counter. Pulses tick on the last cycle of every bit
// while run is high. Assumes div >= 1 (the caller maps 0 to 1) and div
// held stable while run is high.
module sci_tx_baud #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Tick when the count reaches the last cycle of a bit.
    assign tick = run && (cnt == div - 1'b1);

    // Advance the count within a bit, restart at bit boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sci_tx_framer.sv
// Module: builds the whole frame (start, data LSB first, parity, stop) as a
// bit vector with bit 0 sent first, and its length in bits. Positions past
// the frame are filled with ones. An idle request gives all ones.
// Assumes DW >= 2: the short word length is DW-1.
module sci_tx_framer
    import sci_tx_pkg::*;
#(
    parameter int DW = 9,
    localparam int FW = DW + 3,
    localparam int LW = $clog2(FW + 1)
) (
    input  logic          nine,
    input  logic [2:0]    par_mode,
    input  logic          idle,
    input  logic [DW-1:0] data,
    output logic [FW-1:0] frame,
    output logic [LW-1:0] len
);
    int            nbits;
    logic          par_en;
    logic          par_bit;
    logic [DW-1:0] used;

    // Decide the word length, the data bits in use and the parity bit.
    always_comb begin
        nbits   = nine ? DW : DW - 1;
        used    = nine ? data : {1'b0, data[DW-2:0]};
        par_en  = 1'b1;
        par_bit = 1'b1;
        case (par_mode)
            PAR_MARK:  par_bit = 1'b1;
            PAR_SPACE: par_bit = 1'b0;
            PAR_EVEN:  par_bit = ^used;
            PAR_ODD:   par_bit = ~(^used);
            default:   par_en  = 1'b0;
        endcase
    end

    // Lay the bits out in send order.
    always_comb begin
        frame = '1;
        if (!idle) begin
            frame[0] = 1'b0;
            for (int i = 0; i < DW; i++) begin
                if (i < nbits) frame[i+1] = data[i];
            end
            for (int i = DW; i < FW; i++) begin
                if (par_en && i == nbits + 1) frame[i] = par_bit;
            end
        end
        len = LW'(nbits + 2 + (par_en ? 1 : 0));
    end
endmodule

// File: rtl/sci_frame_tx.sv
// Module: top of the serial frame transmitter. Accepts one word or idle
// request per frame on a valid/ready handshake and shifts the prepared
// frame out at one bit per D cycles. Assumes configuration other than the
// divisor is stable from acceptance to the end of the frame.
module sci_frame_tx #(
    parameter int DW    = 9,
    parameter int DIV_W = 13,
    localparam int FW = DW + 3,
    localparam int LW = $clog2(FW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_nine,
    input  logic [2:0]       cfg_par,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_single,
    input  logic             in_valid,
    input  logic             in_idle,
    input  logic [DW-1:0]    in_data,
    output logic             in_ready,
    output logic             busy,
    output logic             txd_o,
    output logic             txd_oe
);
    logic [FW-1:0]    frame;
    logic [LW-1:0]    len;
    logic [FW-1:0]    shreg;
    logic [LW-1:0]    left;
    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic             accept;

    assign in_ready = !busy;
    assign accept   = in_valid && !busy;

    sci_tx_framer #(.DW(DW)) u_framer (
        .nine     (cfg_nine),
        .par_mode (cfg_par),
        .idle     (in_idle),
        .data     (in_data),
        .frame    (frame),
        .len      (len)
    );

    sci_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (busy),
        .div   (div_q),
        .tick  (tick)
    );

    // Load a frame on acceptance, then shift one bit per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
            div_q <= DIV_W'(1);
        end else if (accept) begin
            busy  <= 1'b1;
            shreg <= frame;
            left  <= len;
            div_q <= (cfg_div == '0) ? DIV_W'(1) : cfg_div;
        end else if (busy && tick) begin
            shreg <= {1'b1, shreg[FW-1:1]};
            left  <= left - 1'b1;
            if (left == LW'(1)) busy <= 1'b0;
        end
    end

    // Line rests high between frames; the pin is released there in single-wire mode.
    assign txd_o  = busy ? shreg[0] : 1'b1;
    assign txd_oe = cfg_single ? busy : 1'b1;
endmodule

// File: rtl/sci_frame_tx_chk.sv
// Module: protocol checker for the serial frame transmitter, bound to the top.
module sci_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_single,
    input logic in_valid,
    input logic in_idle,
    input logic in_ready,
    input logic busy,
    input logic txd_o,
    input logic txd_oe
);
    // Start bit is low in the first bit time after a data acceptance.
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_idle) |=> (busy && !txd_o));

    // Line rests high outside frames.
    p_line_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd_o);

    // Idle character begins with a high line.
    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_idle) |=> (busy && txd_o));

    // An accepted request closes the handshake on the next cycle.
    p_no_double_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // Single-wire mode releases the pin between frames.
    p_pin_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_single && !busy) |-> !txd_oe);

    // Normal mode always drives the pin.
    p_pin_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_single |-> txd_oe);
endmodule

bind sci_frame_tx sci_frame_tx_chk u_chk (.*);

// File: tb/sim_sci_frame_tx.sv
`timescale 1ns/1ps
module sim_sci_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_nine = 1'b1;
    logic [2:0]  cfg_par = 3'd0;
    logic [12:0] cfg_div = 13'd1;
    logic        cfg_single = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_idle = 1'b0;
    logic [8:0]  in_data = '0;
    logic        in_ready, busy, txd_o, txd_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sci_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .cfg_nine(cfg_nine), .cfg_par(cfg_par),
        .cfg_div(cfg_div), .cfg_single(cfg_single), .in_valid(in_valid),
        .in_idle(in_idle), .in_data(in_data), .in_ready(in_ready),
        .busy(busy), .txd_o(txd_o), .txd_oe(txd_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Send one request and follow the line bit by bit.
    task automatic send(input logic [8:0] d, input bit idle, input bit nine,
                        input int par, input int div, input bit single);
        bit   exp_bits[12];
        int   nb, len, dd, ones, pos;
        bit   pen, pb;
        string tag;
        @(negedge clk);
        cfg_nine = nine; cfg_par = 3'(par); cfg_div = 13'(div); cfg_single = single;
        in_data = d; in_idle = idle; in_valid = 1'b1;
        chk(in_ready == 1'b1, "R8 ready before accept", int'(in_ready), 1);
        nb   = nine ? 9 : 8;
        ones = $countones(nine ? d : {1'b0, d[7:0]});
        pen  = (par >= 1 && par <= 4);
        pb   = (par == 1) ? 1'b1 : (par == 2) ? 1'b0 :
               (par == 3) ? bit'(ones % 2) : bit'(1 - ones % 2);
        len  = nb + 2 + (pen ? 1 : 0);
        dd   = (div == 0) ? 1 : div;
        for (int i = 0; i < 12; i++) exp_bits[i] = 1'b1;
        if (!idle) begin
            exp_bits[0] = 1'b0;
            for (int i = 0; i < nb; i++) exp_bits[1+i] = d[i];
            if (pen) exp_bits[1+nb] = pb;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_div = 13'(div + 5);           // R6: must not affect this frame
        for (int b = 0; b < len; b++) begin
            for (int c = 0; c < dd; c++) begin
                pos = b;
                if (idle) tag = "R7 idle bit";
                else if (b == 0) tag = "R2 start bit";
                else if (b <= nb) tag = "R3 data bit";
                else if (pen && b == nb + 1) tag = "R4 parity bit";
                else tag = "R5 stop bit";
                chk(txd_o == exp_bits[pos], tag, int'(txd_o), int'(exp_bits[pos]));
                chk(busy && !in_ready, "R8 busy during frame", int'(in_ready), 0);
                chk(txd_oe == 1'b1, "R9 pin driven in frame", int'(txd_oe), 1);
                if (b == 1 && c == 0) begin
                    in_data = ~d; in_idle = ~idle; in_valid = 1'b1;   // R8: refused
                end
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        chk(!busy && in_ready, "R6 frame length / R8 ready after", int'(busy), 0);
        chk(txd_o == 1'b1, "R5 line rests high", int'(txd_o), 1);
        chk(txd_oe == !single, "R9 pin after frame", int'(txd_oe), int'(!single));
    endtask

    initial begin
        logic [8:0] pats[7] = '{9'h000, 9'h1FF, 9'h155, 9'h0AA, 9'h100, 9'h0FF, 9'h001};
        int divs[3] = '{0, 1, 3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd_o == 1'b1 && busy == 1'b0, "R1 reset line/busy", int'(busy), 0);
        chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
        chk(txd_oe == 1'b1, "R1 reset oe normal", int'(txd_oe), 1);
        cfg_single = 1'b1;
        #1;
        chk(txd_oe == 1'b0, "R1 reset oe single", int'(txd_oe), 0);
        for (int n = 0; n < 2; n++)
            for (int p = 0; p < 8; p++)
                for (int v = 0; v < 3; v++)
                    for (int s = 0; s < 2; s++)
                        for (int k = 0; k < 7; k++)
                            send(pats[k], 1'b0, bit'(n), p, divs[v], bit'(s));
        for (int n = 0; n < 2; n++)
            for (int p = 0; p < 8; p++)
                send(9'h0A5, 1'b1, bit'(n), p, 2, 1'b1);
        send(9'h03C, 1'b0, 1'b1, 3, 37, 1'b0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule